// File: doc/BRIEF.md
# Multichannel Input Deglitch Filter Bank

This block qualifies a bank of field input bits and their companion wire-break status bits before the rest of the chip sees them. Every channel has two debounce cells, one on the data bit and one on the wire-break bit. Each cell changes its output only after its input has held a new level for a selected number of timebase ticks. A third cell per channel acts as a fixed-length fault qualifier. It raises the wire-break fault only after the debounced break condition has been present for a set number of millisecond ticks.

The debounce length comes from one of two sources. The first is a 4-bit filter field per channel, held in a configuration register. The second is a global setting taken from two three-level strap pins, which give nine combinations. If any channel's register field is non-zero, the register fields decide for every channel and the strap pins are ignored. A change of source or of length restarts the pending counts. The outputs keep their last levels until the input qualifies again.

Top module: `input_qual_bank`

## Requirements
- R1: A synchronous active-low reset drives every filtered data output and every fault flag to 0 and clears all counters.
- R2: Each strap pin is a 2-bit code: 00 is low (level 0), 01 is high (level 1), and 10 or 11 is float (level 2). The strap index is 3*level(A)+level(B). Index 0 means bypass. Index n>0 sets a debounce length of PIN_BASE*2^(n-1) ticks, which is 1, 2, 4, …, 128 at the defaults.
- R3: In register mode, a channel's 4-bit field value v>0 sets a length of v*REG_SCALE ticks. Channel i's field occupies bits [4i+3:4i] of the register configuration bus. v=0 bypasses that channel.
- R4: When any register field is non-zero, the strap pins have no effect on any channel. Changing them neither alters a length nor restarts a count.
- R5: With length L, an output takes the new input level on the L-th consecutive tick at which the input differs from the output. The change is visible one clock after that tick.
- R6: If the input returns to the output's level before qualification, the count restarts from zero.
- R7: A change of length or source restarts every count. Outputs hold their levels until the input qualifies under the new length.
- R8: The wire-break bit passes through the same programmable debounce as the data bit, using the same length.
- R9: A fault flag rises on the WB_COUNT-th consecutive ms tick at which the debounced wire-break bit is high, and is visible one clock later. The count restarts whenever that bit goes low.
- R10: A bypassed data or wire-break path follows its input with one clock of latency. A fault flag falls one clock after its debounced wire-break bit falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Debounce timebase strobe, one clock wide |
| ms_tick | input | 1 | Millisecond strobe for the fault qualifier |
| ch_in | input | NCH | Raw field input bits |
| wb_in | input | NCH | Raw wire-break status bits |
| reg_cfg | input | NCH*REGW | Per-channel filter fields, channel i at [REGW*i +: REGW] |
| strap_a | input | 2 | First strap pin state code |
| strap_b | input | 2 | Second strap pin state code |
| ch_out | output | NCH | Debounced data bits |
| wb_fault | output | NCH | Qualified wire-break fault flags |

## Verification
A data result is due one clock after the tick that completes its count. In bypass it is due one clock after the input changes. The bench drives its inputs on falling edges and pulses each strobe for exactly one rising edge. It then samples on the next falling edge, so a check either lands on the cycle where a change is due or lands one tick short of it. A fault flag passes through two registers, the wire-break debounce cell and then the qualifier. The bench therefore lets two clocks pass before counting ms ticks and before checking that a flag has cleared. It also checks that the flag is still set after only one clock.

// File: rtl/inq_pkg.sv
package inq_pkg;

    localparam logic [1:0] STRAP_LOW  = 2'b00;
    localparam logic [1:0] STRAP_HIGH = 2'b01;

    // map a strap code to its level (0 low, 1 high, 2 float)
    function automatic int unsigned strap_level(input logic [1:0] code);
        if (code == STRAP_LOW)  return 0;
        if (code == STRAP_HIGH) return 1;
        return 2;
    endfunction

    function automatic int unsigned strap_index(input logic [1:0] a, input logic [1:0] b);
        return 3 * strap_level(a) + strap_level(b);
    endfunction

    // tick length for a strap index; 0 selects bypass
    function automatic int unsigned strap_ticks(input int unsigned idx, input int unsigned base);
        if (idx == 0) return 0;
        return base << (idx - 1);
    endfunction

endpackage

// File: rtl/inq_cfg_arbiter.sv
module inq_cfg_arbiter
    import inq_pkg::*;
#(
    parameter int unsigned NCH       = 8,
    parameter int unsigned REGW      = 4,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned REG_SCALE = 1,
    parameter int unsigned PIN_BASE  = 1
) (
    input  logic [NCH*REGW-1:0]  reg_cfg,
    input  logic [1:0]           strap_a,
    input  logic [1:0]           strap_b,
    output logic                 src_reg,
    output logic [NCH*CNT_W-1:0] lim_flat
);
    logic [CNT_W-1:0] strap_lim;

    always_comb begin
        src_reg   = |reg_cfg;
        strap_lim = CNT_W'(strap_ticks(strap_index(strap_a, strap_b), PIN_BASE));
    end

    for (genvar i = 0; i < NCH; i++) begin : g_lim
        logic [REGW-1:0]  field;
        logic [CNT_W-1:0] reg_lim;
        always_comb begin
            field   = reg_cfg[REGW*i +: REGW];
            reg_lim = CNT_W'(REG_SCALE) * CNT_W'(field);
            lim_flat[CNT_W*i +: CNT_W] = src_reg ? reg_lim : strap_lim;
        end
    end
endmodule

// File: rtl/inq_debounce_cell.sv
module inq_debounce_cell #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             din,
    input  logic             src_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             dout
);
    typedef struct packed {
        logic             out;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             src;
    } cell_st_t;

    cell_st_t st_d, st_q;
    logic     restart;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        restart = (lim_i != st_q.lim) || (src_i != st_q.src);
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        if (restart) begin
            st_d.lim = lim_i;
            st_d.src = src_i;
            st_d.cnt = '0;
            if (lim_i == '0) st_d.out = din;
        end else if (lim_i == '0) begin
            st_d.out = din;
            st_d.cnt = '0;
        end else if (din == st_q.out) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (cnt_inc >= {1'b0, lim_i}) begin
                st_d.out = din;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_inc[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.out;

    // R5
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && lim_i != '0 && !tick) |=> $stable(st_q.out));

    // R6
    reversal_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && lim_i != '0 && din == st_q.out) |=> (st_q.cnt == '0));

    // R7
    restart_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && lim_i != '0) |=> ($stable(st_q.out) && st_q.cnt == '0));

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lim != '0) |-> (st_q.cnt < st_q.lim));
endmodule

// File: rtl/inq_fault_qual.sv
module inq_fault_qual #(
    parameter int unsigned WB_COUNT = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic din,
    output logic flag
);
    localparam int unsigned QW = $clog2(WB_COUNT + 1);

    typedef struct packed {
        logic          flag;
        logic [QW-1:0] cnt;
    } qual_st_t;

    qual_st_t st_d, st_q;
    logic [QW:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = {1'b0, st_q.cnt} + 1'b1;
        if (!din) begin
            st_d.flag = 1'b0;
            st_d.cnt  = '0;
        end else if (!st_q.flag && ms_tick) begin
            if (cnt_inc >= (QW+1)'(WB_COUNT)) begin
                st_d.flag = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = cnt_inc[QW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R10
    clear_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !din |=> !st_q.flag);

    // R9
    rise_on_ms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> ($past(ms_tick) && $past(din)));
endmodule

// File: rtl/input_qual_bank.sv
module input_qual_bank
    import inq_pkg::*;
#(
    parameter int unsigned NCH       = 8,
    parameter int unsigned REGW      = 4,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned REG_SCALE = 1,
    parameter int unsigned PIN_BASE  = 1,
    parameter int unsigned WB_COUNT  = 30
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                ms_tick,
    input  logic [NCH-1:0]      ch_in,
    input  logic [NCH-1:0]      wb_in,
    input  logic [NCH*REGW-1:0] reg_cfg,
    input  logic [1:0]          strap_a,
    input  logic [1:0]          strap_b,
    output logic [NCH-1:0]      ch_out,
    output logic [NCH-1:0]      wb_fault
);
    logic                 src_reg;
    logic [NCH*CNT_W-1:0] lim_flat;
    logic [NCH-1:0]       wb_deb;

    inq_cfg_arbiter #(
        .NCH(NCH), .REGW(REGW), .CNT_W(CNT_W),
        .REG_SCALE(REG_SCALE), .PIN_BASE(PIN_BASE)
    ) arb_i (
        .reg_cfg (reg_cfg),
        .strap_a (strap_a),
        .strap_b (strap_b),
        .src_reg (src_reg),
        .lim_flat(lim_flat)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        inq_debounce_cell #(.CNT_W(CNT_W)) data_i (
            .clk(clk), .rst_n(rst_n), .tick(tick), .din(ch_in[i]),
            .src_i(src_reg), .lim_i(lim_flat[CNT_W*i +: CNT_W]), .dout(ch_out[i])
        );
        inq_debounce_cell #(.CNT_W(CNT_W)) brk_i (
            .clk(clk), .rst_n(rst_n), .tick(tick), .din(wb_in[i]),
            .src_i(src_reg), .lim_i(lim_flat[CNT_W*i +: CNT_W]), .dout(wb_deb[i])
        );
        inq_fault_qual #(.WB_COUNT(WB_COUNT)) qual_i (
            .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
            .din(wb_deb[i]), .flag(wb_fault[i])
        );
    end

    // R4
    straps_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_reg && $stable(reg_cfg)) |-> $stable(lim_flat));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ch_out == '0 && wb_fault == '0));
endmodule

// File: tb/input_qual_bank_tb_top.sv
module input_qual_bank_tb_top;
    localparam int CLK_P = 10;
    localparam int NCH = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic tick = 0, ms_tick = 0;
    logic [NCH-1:0] ch_in = '0, wb_in = '0;
    logic [NCH*4-1:0] reg_cfg = '0;
    logic [1:0] strap_a = 2'b00, strap_b = 2'b00;
    logic [NCH-1:0] ch_out, wb_fault;

    int n_chk = 0, n_err = 0;
    logic [NCH-1:0] cur;

    always #(CLK_P/2) clk = ~clk;

    input_qual_bank dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ms_tick(ms_tick),
        .ch_in(ch_in), .wb_in(wb_in), .reg_cfg(reg_cfg),
        .strap_a(strap_a), .strap_b(strap_b),
        .ch_out(ch_out), .wb_fault(wb_fault)
    );

    task automatic check(input string tag, input logic [NCH-1:0] got, input logic [NCH-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1; @(negedge clk); tick = 0;
        end
    endtask

    task automatic msticks(input int n);
        for (int k = 0; k < n; k++) begin
            ms_tick = 1; @(negedge clk); ms_tick = 0;
        end
    endtask

    function automatic logic [1:0] code_of(input int lvl, input bit alt);
        if (lvl == 0) return 2'b00;
        if (lvl == 1) return 2'b01;
        return alt ? 2'b11 : 2'b10;
    endfunction

    task automatic set_strap(input int idx);
        strap_a = code_of(idx / 3, 1'b0);
        strap_b = code_of(idx % 3, idx == 5);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        step(3);
        // R1 reset state
        check("R1", ch_out, '0);
        check("R1", wb_fault, '0);
        rst_n = 1;
        cur = '0;

        // R2 R5 R6 R10: sweep all nine strap indices
        for (int idx = 0; idx < 9; idx++) begin
            int len;
            len = (idx == 0) ? 0 : (1 << (idx - 1));
            set_strap(idx);
            step(2);
            ch_in = ~cur;
            step(1);
            if (len == 0) begin
                check("R10", ch_out, ~cur);
                cur = ~cur;
            end else begin
                ticks(len - 1);
                check("R5", ch_out, cur);
                if (len >= 2) begin
                    ch_in = cur; step(1); ch_in = ~cur;
                    ticks(len - 1);
                    check("R6", ch_out, cur);
                end
                ticks(1);
                check("R2", ch_out, ~cur);
                cur = ~cur;
            end
        end

        // R3: channel i field = i, ch0 bypassed
        for (int i = 0; i < NCH; i++) reg_cfg[4*i +: 4] = 4'(i);
        set_strap(8);
        step(2);
        ch_in = ~cur;
        step(1);
        check("R3", {7'b0, ch_out[0]}, {7'b0, ~cur[0]});
        for (int k = 1; k < NCH; k++) begin
            logic [NCH-1:0] exp;
            ticks(1);
            exp = cur;
            for (int i = 0; i < NCH; i++)
                if (i == 0 || k >= i) exp[i] = ~cur[i];
            check("R3", ch_out, exp);
        end
        cur = ~cur;

        // R4: strap change mid-count has no effect in register mode
        ch_in = ~cur;
        step(1);
        ticks(2);
        set_strap(4);
        step(1);
        ticks(1);
        check("R4", ch_out & 8'h18, (cur & 8'h10) | (~cur & 8'h08));
        ticks(4);
        check("R4", ch_out, ~cur);
        cur = ~cur;

        // R7: length change restarts counts, outputs hold
        reg_cfg = '0;
        set_strap(3);
        step(2);
        ch_in = ~cur;
        step(1);
        ticks(3);
        check("R7", ch_out, cur);
        set_strap(4);
        step(1);
        ticks(7);
        check("R7", ch_out, cur);
        ticks(1);
        check("R7", ch_out, ~cur);
        cur = ~cur;

        // R9: fault qualifier in bypass
        set_strap(0);
        step(2);
        wb_in = 8'h04;
        step(2);
        check("R10", wb_fault, '0);
        msticks(29);
        check("R9", wb_fault, '0);
        msticks(1);
        check("R9", wb_fault, 8'h04);
        wb_in = '0;
        step(1);
        check("R10", wb_fault, 8'h04);
        step(1);
        check("R10", wb_fault, '0);
        wb_in = 8'h04;
        step(2);
        msticks(20);
        wb_in = '0; step(3); wb_in = 8'h04; step(2);
        msticks(29);
        check("R9", wb_fault, '0);
        msticks(1);
        check("R9", wb_fault, 8'h04);
        wb_in = '0;
        step(2);
        check("R9", wb_fault, '0);

        // R8: wire-break path uses the programmable debounce
        set_strap(3);
        step(2);
        wb_in = 8'h20;
        step(2);
        msticks(40);
        check("R8", wb_fault, '0);
        ticks(4);
        step(1);
        msticks(29);
        check("R8", wb_fault, '0);
        msticks(1);
        check("R8", wb_fault, 8'h20);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule